// File: doc/BRIEF.md
# Multiplexed Bus Device-Side Demultiplexer

This block sits on the device side of a bank whose address and data share one set of pins. The host drives no address strobe, so the block makes its own. When chip select goes low it takes the word on the shared pins as the address. It then gives a local memory or register file a separate address, write data and write strobe, and it returns read data onto the shared pins only when a read beat is in progress.

One address bit marks a four-beat burst. When that flag is set in the captured address, the host sends no further address phases. The block then works out the address of each later beat itself, one word apart. A single access gets one beat. Any extra beats inside the same select are dropped until chip select is released.

All inputs are sampled on the rising edge of `clk`, and every output comes from a register. The local storage is expected to return `loc_rdata` for the current `loc_addr` within the same cycle, the way a register file does.

Top module: `mbd_demux`

## Requirements
- R1: While and right after `rst` is high, `addr_strobe`, `loc_we` and `bus_drive` are 0.
- R2: `addr_strobe` is 1 for exactly one cycle. That cycle follows the first rising clock edge at which `cs_n` is sampled low after it was sampled high. It stays 0 for as long as `cs_n` is held low afterwards.
- R3: At that same edge the block captures `bus_in[ADDR_W-1:0]`. `loc_addr` then shows the captured value with bit `ADDR_W-1` (bit 21 by default, the burst flag) forced to 0.
- R4: If the burst flag in the captured address is 0, the access is a single access. Only the first completed beat is accepted. Later beats cause no `loc_we`, no `bus_drive` and no change of `loc_addr`.
- R5: If the burst flag is 1, exactly four completed beats are accepted, at addresses A, A+4, A+8 and A+12, where A is the masked captured address. A fifth beat is ignored in the same way as in R4.
- R6: A write beat completes when `we_n` is sampled high after it was sampled low, inside an accepted data phase. In the next cycle `loc_we` is 1 for one cycle, and `loc_wdata` holds the `bus_in` value sampled one edge before `we_n` was seen high. `loc_addr` holds the beat address during that cycle.
- R7: `bus_drive` is 1 in the cycle after an edge at which `cs_n` and `oe_n` are both sampled low, a data phase is active and beats remain. In that cycle `bus_out` equals `loc_rdata` for the current `loc_addr`. In every other cycle, including the address cycle, `bus_drive` is 0.
- R8: A read beat completes when `oe_n` is sampled high after it was sampled low. One cycle after any completed beat, `loc_addr` moves to the next beat address.
- R9: Sampling `cs_n` high ends the access. Strobes seen while `cs_n` is high are ignored. The next fall of `cs_n` starts a new address phase.
- R10: The burst address steps in bits `ADDR_W-2` down to 2 and wraps within that field. Bits 1:0 stay at their captured value, so 0x1FFFFD is followed by 0x000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Bank select from the host, active low |
| oe_n | input | 1 | Read strobe from the host, active low |
| we_n | input | 1 | Write strobe from the host, active low |
| bus_in | input | DATA_W | Shared address/data pins as seen by the device |
| bus_out | output | DATA_W | Read data to place on the shared pins |
| bus_drive | output | 1 | Output enable for the shared pins; 0 means tri-stated |
| addr_strobe | output | 1 | Address strobe generated inside the block, one cycle wide |
| loc_addr | output | ADDR_W | Local word address with the burst flag cleared |
| loc_wdata | output | DATA_W | Local write data |
| loc_we | output | 1 | Local write strobe, one cycle wide |
| loc_rdata | input | DATA_W | Read data from local storage for `loc_addr` |

## Verification
The results of this block fall due at different points, and the bench checks each one at its own point.

- `addr_strobe`, the captured `loc_addr` and `bus_drive` appear one edge after the stimulus that causes them.
- `loc_we` with its data appears one edge after `we_n` is seen rising.
- The stepped `loc_addr` appears two edges after the rising strobe.

The bench drives every input on a falling clock edge and reads outputs on the falling edge that follows the expected rising edge, so each check lands exactly in its due cycle. A scoreboard queue holds the expected writes, and a monitor flags any write strobe that has no matching entry. This catches both writes that were dropped and writes that should have been ignored.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
  localparam int unsigned BURST_BEATS = 4;
  localparam int unsigned BEAT_CNT_W  = $clog2(BURST_BEATS + 1);
  localparam int unsigned WORD_SHIFT  = 2;
  typedef logic [BEAT_CNT_W-1:0] beat_cnt_t;
endpackage

// File: rtl/mbd_edge_det.sv
module mbd_edge_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) prev_q[g] <= 1'b1;
      else     prev_q[g] <= lvl_n[g];
    end
    assign fall[g] = prev_q[g] & ~lvl_n[g];
    assign rise[g] = ~prev_q[g] & lvl_n[g];
  end
endmodule

// File: rtl/mbd_addr_seq.sv
module mbd_addr_seq
  import mbd_pkg::*;
#(
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              cs_fall,
  input  logic              beat_end,
  input  logic [ADDR_W-1:0] cap_bus,
  output logic              strobe,
  output logic              active,
  output logic              beats_nz,
  output logic              accept,
  output logic [ADDR_W-1:0] beat_addr
);
  localparam int unsigned FLAG_BIT = ADDR_W - 1;
  localparam int unsigned STEP_W   = ADDR_W - 1 - WORD_SHIFT;

  beat_cnt_t   left_q;
  logic        adv_q;
  logic [STEP_W-1:0] step_field;

  assign beats_nz   = (left_q != '0);
  assign accept     = active & beats_nz & ~cs_n & beat_end;
  assign step_field = beat_addr[ADDR_W-2:WORD_SHIFT] + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe    <= 1'b0;
      active    <= 1'b0;
      left_q    <= '0;
      adv_q     <= 1'b0;
      beat_addr <= '0;
    end else begin
      strobe <= cs_fall;
      adv_q  <= accept;
      if (cs_n) begin
        active <= 1'b0;
        left_q <= '0;
      end else if (cs_fall) begin
        active    <= 1'b1;
        left_q    <= cap_bus[FLAG_BIT] ? beat_cnt_t'(BURST_BEATS) : beat_cnt_t'(1);
        beat_addr <= {1'b0, cap_bus[ADDR_W-2:0]};
      end else begin
        if (accept) left_q <= left_q - beat_cnt_t'(1);
        if (adv_q)  beat_addr <= {1'b0, step_field, beat_addr[WORD_SHIFT-1:0]};
      end
    end
  end

  assert_strobe_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
  assert_beats_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    left_q <= beat_cnt_t'(BURST_BEATS));
  assert_low_bits_kept_R10: assert property (@(posedge clk) disable iff (rst)
    adv_q && !cs_fall |=> beat_addr[WORD_SHIFT-1:0] == $past(beat_addr[WORD_SHIFT-1:0]));
  assert_no_beat_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !beats_nz);
endmodule

// File: rtl/mbd_wr_path.sv
module mbd_wr_path #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              we_rise,
  input  logic [DATA_W-1:0] bus_in,
  output logic              loc_we,
  output logic [DATA_W-1:0] loc_wdata
);
  logic [DATA_W-1:0] bus_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_prev_q <= '0;
      loc_we     <= 1'b0;
      loc_wdata  <= '0;
    end else begin
      bus_prev_q <= bus_in;
      loc_we     <= accept & we_rise;
      if (accept & we_rise) loc_wdata <= bus_prev_q;
    end
  end

  assert_we_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    loc_we |=> !loc_we);
endmodule

// File: rtl/mbd_rd_path.sv
module mbd_rd_path #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              beats_nz,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] loc_rdata,
  output logic              bus_drive,
  output logic [DATA_W-1:0] bus_out
);
  logic drive_d;
  assign drive_d = active & beats_nz & ~oe_n & ~cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_drive <= 1'b0;
      bus_out   <= '0;
    end else begin
      bus_drive <= drive_d;
      bus_out   <= drive_d ? loc_rdata : '0;
    end
  end

  assert_drive_needs_read_R7: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> $past(!oe_n) && $past(!cs_n));
endmodule

// File: rtl/mbd_demux.sv
module mbd_demux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_drive,
  output logic              addr_strobe,
  output logic [ADDR_W-1:0] loc_addr,
  output logic [DATA_W-1:0] loc_wdata,
  output logic              loc_we,
  input  logic [DATA_W-1:0] loc_rdata
);
  localparam int unsigned IDX_CS = 0;
  localparam int unsigned IDX_OE = 1;
  localparam int unsigned IDX_WE = 2;

  logic [2:0] fall, rise;
  logic       active, beats_nz, accept;

  mbd_edge_det #(.N(3)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .lvl_n({we_n, oe_n, cs_n}),
    .fall (fall),
    .rise (rise)
  );

  mbd_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .cs_fall  (fall[IDX_CS]),
    .beat_end (rise[IDX_OE] | rise[IDX_WE]),
    .cap_bus  (bus_in[ADDR_W-1:0]),
    .strobe   (addr_strobe),
    .active   (active),
    .beats_nz (beats_nz),
    .accept   (accept),
    .beat_addr(loc_addr)
  );

  mbd_wr_path #(.DATA_W(DATA_W)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .we_rise  (rise[IDX_WE]),
    .bus_in   (bus_in),
    .loc_we   (loc_we),
    .loc_wdata(loc_wdata)
  );

  mbd_rd_path #(.DATA_W(DATA_W)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .active   (active),
    .beats_nz (beats_nz),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .loc_rdata(loc_rdata),
    .bus_drive(bus_drive),
    .bus_out  (bus_out)
  );

  assert_addr_captured_R3: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |-> loc_addr == {1'b0, $past(bus_in[ADDR_W-2:0])});
  assert_no_drive_in_addr_R7: assert property (@(posedge clk) disable iff (rst)
    addr_strobe |-> !bus_drive);
  assert_idle_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !addr_strobe && !loc_we && !bus_drive);
endmodule

// File: tb/test_mbd_demux.sv
module test_mbd_demux;
  localparam int DW = 32;
  localparam int AW = 22;
  localparam logic [AW-1:0] FLAG = 22'h200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [DW-1:0] bus_in = '0;
  logic [DW-1:0] bus_out, loc_wdata, loc_rdata;
  logic bus_drive, addr_strobe, loc_we;
  logic [AW-1:0] loc_addr;

  int vectors = 0;
  int errs = 0;
  bit done = 0;
  logic [AW+DW-1:0] exp_q[$];

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mem_model(input logic [AW-1:0] a);
    return 32'hA5000000 ^ {10'b0, a} ^ {a[9:0], 22'b0};
  endfunction

  assign loc_rdata = mem_model(loc_addr);

  mbd_demux #(.DATA_W(DW), .ADDR_W(AW)) i_mbd_demux (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_drive(bus_drive),
    .addr_strobe(addr_strobe), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
    .loc_we(loc_we), .loc_rdata(loc_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every write strobe must match the oldest expected write
  initial begin
    forever begin
      @(negedge clk);
      if (loc_we) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected write", {32'b0, loc_wdata}, 0);
        else begin
          logic [AW+DW-1:0] e;
          e = exp_q.pop_front();
          chk({loc_addr, loc_wdata} == e, "R6 write item", {loc_addr, loc_wdata}, e);
        end
      end
    end
  end

  function automatic logic [AW-1:0] next_beat(input logic [AW-1:0] a);
    logic [AW-4:0] f;
    f = a[AW-2:2] + 1'b1;
    return {1'b0, f, a[1:0]};
  endfunction

  task automatic select(input logic [AW-1:0] a);
    cs_n = 1'b0; bus_in = {10'h3C5, a};
    @(negedge clk);
    chk(addr_strobe == 1'b1, "R2 strobe", addr_strobe, 1);
    chk(loc_addr == (a & ~FLAG), "R3 captured addr", loc_addr, a & ~FLAG);
    bus_in = 32'hDEAD0000;
    @(negedge clk);
    chk(addr_strobe == 1'b0, "R2 strobe width", addr_strobe, 0);
  endtask

  task automatic deselect();
    cs_n = 1'b1; bus_in = '0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_beat(input logic [DW-1:0] d, input logic [AW-1:0] a, input bit ok);
    bus_in = d; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    if (ok) exp_q.push_back({a, d});
    @(negedge clk);
    #1;
    chk(exp_q.size() == 0, ok ? "R6 write seen" : "R4 write ignored", exp_q.size(), 0);
    @(negedge clk);
    if (ok) chk(loc_addr == next_beat(a), "R8 advance after write", loc_addr, next_beat(a));
    else    chk(loc_addr == a, "R4 addr held", loc_addr, a);
  endtask

  task automatic rd_beat(input logic [AW-1:0] a, input bit ok);
    oe_n = 1'b0;
    @(negedge clk);
    chk(bus_drive == ok, ok ? "R7 drive on read" : "R5 drive ignored", bus_drive, ok);
    if (ok) chk(bus_out == mem_model(a), "R7 read data", bus_out, mem_model(a));
    oe_n = 1'b1;
    @(negedge clk);
    chk(bus_drive == 1'b0, "R7 release", bus_drive, 0);
    @(negedge clk);
    if (ok) chk(loc_addr == next_beat(a), "R8 advance after read", loc_addr, next_beat(a));
    else    chk(loc_addr == a, "R5 addr held", loc_addr, a);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(negedge clk);
    chk(!addr_strobe && !loc_we && !bus_drive, "R1 reset", {addr_strobe, loc_we, bus_drive}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!addr_strobe && !loc_we && !bus_drive, "R1 after reset", {addr_strobe, loc_we, bus_drive}, 0);

    // R4: single write, second beat ignored
    select(22'h000123);
    wr_beat(32'h11223344, 22'h000123, 1);
    wr_beat(32'h55667788, 22'h000127, 0);
    deselect();

    // R4/R7: single read, second not driven
    select(22'h000040);
    rd_beat(22'h000040, 1);
    rd_beat(22'h000044, 0);
    deselect();

    // R5: burst write, four beats then ignored
    a = 22'h000101;
    select(FLAG | a);
    for (int i = 0; i < 4; i++) begin
      wr_beat(32'hB0000000 + i, a, 1);
      a = next_beat(a);
    end
    wr_beat(32'hBAD0BAD0, a, 0);
    deselect();

    // R10: burst read wrapping the step field
    a = 22'h1FFFFD;
    select(FLAG | a);
    for (int i = 0; i < 4; i++) begin
      rd_beat(a, 1);
      a = next_beat(a);
    end
    chk(a == 22'h00000D, "R10 wrap model", a, 22'h00000D);
    rd_beat(a, 0);
    deselect();

    // R5: mixed burst, alternating read and write
    a = 22'h0F0002;
    select(FLAG | a);
    for (int i = 0; i < 4; i++) begin
      if (i % 2 == 0) rd_beat(a, 1);
      else            wr_beat(32'hC0DE0000 + i, a, 1);
      a = next_beat(a);
    end
    deselect();

    // R9: end burst early, strobes while deselected ignored, new select
    a = 22'h000800;
    select(FLAG | a);
    wr_beat(32'h0A0A0A0A, a, 1);
    cs_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b0;
    @(negedge clk);
    chk(bus_drive == 1'b0, "R9 no drive when deselected", bus_drive, 0);
    oe_n = 1'b1; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!loc_we && !addr_strobe, "R9 no write when deselected", {loc_we, addr_strobe}, 0);
    select(22'h000300);
    rd_beat(22'h000300, 1);
    deselect();

    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule